// File: doc/BRIEF.md
# SDRAM Mode-Steered Command Issuer

This block sits between a system bus and an SDRAM device. It turns a single bus write into one SDRAM command. A small mode field, written through a register port, decides what the next write to the memory space does. In normal mode the write goes out as an ordinary SDRAM write command and the data is driven on the data pins. In any other mode the write issues one control command instead: a no-operation, a precharge of all banks, one auto-refresh, a load of the mode register, or a load of the extended mode register. Software runs the power-up and configuration sequence this way. It sets the mode, performs a write, and repeats as needed.

For the two mode-register loads, the write address supplies the value. The low address bits go to the SDRAM address pins and the bits above them go to the bank-address pins. For the other special commands the write address has no effect.

Each accepted write produces exactly one command cycle with chip select low. The write is acknowledged in the following cycle. The mode field keeps its value until software writes it again.

Top module: `sdcmd_issuer`

## Requirements
- R1: After reset, chip select is high, (RAS#, CAS#, WE#) read 111, the acknowledge is low, the data pins are not driven, and the mode field is 0.
- R2: In mode 0 an accepted write issues a write command, (RAS#, CAS#, WE#) = 100. The address pins carry mem_addr[ROW_W-1:0] with bit AP_BIT forced low. The bank pins carry mem_addr[ROW_W+BANK_W-1:ROW_W]. The write data is driven with the output enable high for that cycle.
- R3: In mode 1 an accepted write issues a NOP, (RAS#, CAS#, WE#) = 111, with chip select low. The address and bank pins are zero.
- R4: In mode 2 an accepted write issues precharge-all, encoded 010. Address pin AP_BIT is high, every other address pin is zero, and the bank pins are zero, whatever the write address.
- R5: In mode 3 an accepted write issues a mode-register load, encoded 000. The address and bank pins take the write-address split described in R2, with no bit forced.
- R6: In mode 4 each accepted write issues exactly one auto-refresh, encoded 001, so N writes give N refresh commands.
- R7: In mode 5 an accepted write issues an extended mode-register load, encoded 000, with the same address and bank split as R5.
- R8: Mode values 6 and 7 behave exactly like mode 1.
- R9: Each accepted write yields exactly one cycle with chip select low. mem_ack is high for exactly the one cycle after that command cycle.
- R10: The mode field changes only on a register write. Any number of memory writes leave it unchanged.
- R11: A register write on the same clock edge that accepts a memory write does not affect that write. The new mode applies from the next accepted write onward.
- R12: The data output enable is high only during a write command. It is never high during a special command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Mode field write strobe |
| cfg_mode | input | 3 | Mode value to write |
| mem_req | input | 1 | Memory write request, held until acknowledged |
| mem_addr | input | ROW_W+BANK_W | Memory write address |
| mem_wdata | input | DATA_W | Memory write data |
| mem_ack | output | 1 | One-cycle write acknowledge |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | SDRAM row strobe, active low |
| sd_cas_n | output | 1 | SDRAM column strobe, active low |
| sd_we_n | output | 1 | SDRAM write enable, active low |
| sd_addr | output | ROW_W | SDRAM address pins |
| sd_ba | output | BANK_W | SDRAM bank-address pins |
| sd_dq | output | DATA_W | SDRAM write data |
| sd_dq_oe | output | 1 | Data output enable |

## Verification
A corrupted mode field shows up on the first accepted write after the corruption. The command bits, the forced A10 or the address passthrough differ from the expected values in the cycle right after acceptance. A sequencer stuck in one state shows up within two cycles of a request: chip select stays low for more than one cycle, the acknowledge repeats, or the acknowledge never arrives. The same-edge collision test exposes a design that decodes the newly written mode instead of the mode held at acceptance. Repeated refresh writes expose any mode field that clears itself after use.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  // Mode field values
  localparam logic [2:0] MODE_NORMAL  = 3'd0;
  localparam logic [2:0] MODE_NOP     = 3'd1;
  localparam logic [2:0] MODE_PRECH   = 3'd2;
  localparam logic [2:0] MODE_LMR     = 3'd3;
  localparam logic [2:0] MODE_REFRESH = 3'd4;
  localparam logic [2:0] MODE_XLMR    = 3'd5;

  // Command encodings on {RAS#, CAS#, WE#}
  localparam logic [2:0] CMD_MRS = 3'b000;
  localparam logic [2:0] CMD_REF = 3'b001;
  localparam logic [2:0] CMD_PRE = 3'b010;
  localparam logic [2:0] CMD_WR  = 3'b100;
  localparam logic [2:0] CMD_NOP = 3'b111;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_CMD  = 2'd1,
    SEQ_ACK  = 2'd2
  } seq_e;

endpackage

// File: rtl/sdcmd_mode_reg.sv
module sdcmd_mode_reg #(
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [MODE_W-1:0] cfg_mode,
  output logic [MODE_W-1:0] mode_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
    end else if (cfg_we) begin
      mode_q <= cfg_mode;
    end
  end

  // R10: no register write, no change
  p_mode_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> $stable(mode_q));

endmodule

// File: rtl/sdcmd_seq.sv
module sdcmd_seq
  import sdcmd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic accept,
  output logic ack
);

  seq_e state_q;

  assign accept = (state_q == SEQ_IDLE) && req;
  assign ack    = (state_q == SEQ_ACK);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (req) state_q <= SEQ_CMD;
        SEQ_CMD:  state_q <= SEQ_ACK;
        SEQ_ACK:  state_q <= SEQ_IDLE;
        default:  state_q <= SEQ_IDLE;
      endcase
    end
  end

  // R9: acknowledge lasts a single cycle
  p_ack_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  // R9: an acceptance is followed by acknowledge two edges later
  p_accept_to_ack_r9: assert property (@(posedge clk) disable iff (rst)
    accept |=> !ack ##1 ack);

endmodule

// File: rtl/sdcmd_encode.sv
module sdcmd_encode
  import sdcmd_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int BANK_W = 2,
  parameter int DATA_W = 16,
  parameter int AP_BIT = 10,
  localparam int ADDR_W = ROW_W + BANK_W
) (
  input  logic [2:0]        mode,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_wdata,
  output logic [2:0]        cmd,
  output logic [ROW_W-1:0]  addr,
  output logic [BANK_W-1:0] ba,
  output logic              oe,
  output logic [DATA_W-1:0] dq
);

  logic [ROW_W-1:0]  raw_addr;
  logic [ROW_W-1:0]  wr_addr;
  logic [ROW_W-1:0]  pre_addr;
  logic [BANK_W-1:0] raw_ba;

  assign raw_addr = mem_addr[ROW_W-1:0];
  assign raw_ba   = mem_addr[ROW_W +: BANK_W];

  // Write column: auto-precharge bit held low; precharge: only that bit high
  for (genvar i = 0; i < ROW_W; i++) begin : g_abit
    if (i == AP_BIT) begin : g_ap
      assign wr_addr[i]  = 1'b0;
      assign pre_addr[i] = 1'b1;
    end else begin : g_pass
      assign wr_addr[i]  = raw_addr[i];
      assign pre_addr[i] = 1'b0;
    end
  end

  always_comb begin
    cmd  = CMD_NOP;
    addr = '0;
    ba   = '0;
    oe   = 1'b0;
    dq   = mem_wdata;
    unique case (mode)
      MODE_NORMAL: begin
        cmd  = CMD_WR;
        addr = wr_addr;
        ba   = raw_ba;
        oe   = 1'b1;
      end
      MODE_PRECH: begin
        cmd  = CMD_PRE;
        addr = pre_addr;
      end
      MODE_REFRESH: cmd = CMD_REF;
      MODE_LMR, MODE_XLMR: begin
        cmd  = CMD_MRS;
        addr = raw_addr;
        ba   = raw_ba;
      end
      default: cmd = CMD_NOP;
    endcase
  end

endmodule

// File: rtl/sdcmd_outreg.sv
module sdcmd_outreg
  import sdcmd_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int BANK_W = 2,
  parameter int DATA_W = 16,
  parameter int AP_BIT = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [2:0]        cmd,
  input  logic [ROW_W-1:0]  addr,
  input  logic [BANK_W-1:0] ba,
  input  logic              oe,
  input  logic [DATA_W-1:0] dq,
  output logic              cs_n_q,
  output logic [2:0]        cmd_q,
  output logic [ROW_W-1:0]  addr_q,
  output logic [BANK_W-1:0] ba_q,
  output logic              oe_q,
  output logic [DATA_W-1:0] dq_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n_q <= 1'b1;
      cmd_q  <= CMD_NOP;
      addr_q <= '0;
      ba_q   <= '0;
      oe_q   <= 1'b0;
      dq_q   <= '0;
    end else if (load) begin
      cs_n_q <= 1'b0;
      cmd_q  <= cmd;
      addr_q <= addr;
      ba_q   <= ba;
      oe_q   <= oe;
      dq_q   <= dq;
    end else begin
      cs_n_q <= 1'b1;
      cmd_q  <= CMD_NOP;
      oe_q   <= 1'b0;
    end
  end

  // R9: chip select low for one cycle at a time
  p_cs_single_r9: assert property (@(posedge clk) disable iff (rst)
    !cs_n_q |=> cs_n_q);

  // R12: data driven only alongside a write command
  p_oe_write_only_r12: assert property (@(posedge clk) disable iff (rst)
    oe_q |-> (!cs_n_q && cmd_q == CMD_WR));

  // R4: precharge always carries the all-banks bit
  p_pre_all_r4: assert property (@(posedge clk) disable iff (rst)
    (!cs_n_q && cmd_q == CMD_PRE) |-> addr_q[AP_BIT]);

  // R2: write never requests auto-precharge
  p_wr_no_ap_r2: assert property (@(posedge clk) disable iff (rst)
    (!cs_n_q && cmd_q == CMD_WR) |-> !addr_q[AP_BIT]);

endmodule

// File: rtl/sdcmd_issuer.sv
module sdcmd_issuer
  import sdcmd_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int BANK_W = 2,
  parameter int DATA_W = 16,
  parameter int AP_BIT = 10,
  localparam int ADDR_W = ROW_W + BANK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_mode,
  input  logic              mem_req,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_wdata,
  output logic              mem_ack,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ROW_W-1:0]  sd_addr,
  output logic [BANK_W-1:0] sd_ba,
  output logic [DATA_W-1:0] sd_dq,
  output logic              sd_dq_oe
);

  logic [2:0]        mode_q;
  logic              accept;
  logic [2:0]        nxt_cmd;
  logic [ROW_W-1:0]  nxt_addr;
  logic [BANK_W-1:0] nxt_ba;
  logic              nxt_oe;
  logic [DATA_W-1:0] nxt_dq;
  logic [2:0]        cmd_q;

  sdcmd_mode_reg #(.MODE_W(3)) u_mode (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mode(cfg_mode), .mode_q(mode_q)
  );

  sdcmd_seq u_seq (
    .clk(clk), .rst(rst), .req(mem_req), .accept(accept), .ack(mem_ack)
  );

  sdcmd_encode #(
    .ROW_W(ROW_W), .BANK_W(BANK_W), .DATA_W(DATA_W), .AP_BIT(AP_BIT)
  ) u_enc (
    .mode(mode_q), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .cmd(nxt_cmd), .addr(nxt_addr), .ba(nxt_ba), .oe(nxt_oe), .dq(nxt_dq)
  );

  sdcmd_outreg #(
    .ROW_W(ROW_W), .BANK_W(BANK_W), .DATA_W(DATA_W), .AP_BIT(AP_BIT)
  ) u_out (
    .clk(clk), .rst(rst), .load(accept),
    .cmd(nxt_cmd), .addr(nxt_addr), .ba(nxt_ba), .oe(nxt_oe), .dq(nxt_dq),
    .cs_n_q(sd_cs_n), .cmd_q(cmd_q), .addr_q(sd_addr), .ba_q(sd_ba),
    .oe_q(sd_dq_oe), .dq_q(sd_dq)
  );

  assign sd_ras_n = cmd_q[2];
  assign sd_cas_n = cmd_q[1];
  assign sd_we_n  = cmd_q[0];

  // R9: acknowledge follows the command cycle
  p_ack_after_cmd_r9: assert property (@(posedge clk) disable iff (rst)
    !sd_cs_n |=> mem_ack);

  // R9: no command while acknowledging
  p_no_cmd_in_ack_r9: assert property (@(posedge clk) disable iff (rst)
    mem_ack |-> sd_cs_n);

endmodule

// File: tb/sdcmd_issuer_bench.sv
module sdcmd_issuer_bench;

  localparam int ROW_W  = 13;
  localparam int BANK_W = 2;
  localparam int DATA_W = 16;
  localparam int ADDR_W = ROW_W + BANK_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_we = 1'b0;
  logic [2:0]        cfg_mode = '0;
  logic              mem_req = 1'b0;
  logic [ADDR_W-1:0] mem_addr = '0;
  logic [DATA_W-1:0] mem_wdata = '0;
  logic              mem_ack;
  logic              sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [ROW_W-1:0]  sd_addr;
  logic [BANK_W-1:0] sd_ba;
  logic [DATA_W-1:0] sd_dq;
  logic              sd_dq_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // captured snapshot
  logic              c_cs, c_oe, c_ack0, c_ack1, c_cs1;
  logic [2:0]        c_cmd;
  logic [ROW_W-1:0]  c_addr;
  logic [BANK_W-1:0] c_ba;
  logic [DATA_W-1:0] c_dq;

  always #2 clk = ~clk;

  sdcmd_issuer u_sdcmd_issuer (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr),
    .sd_ba(sd_ba), .sd_dq(sd_dq), .sd_dq_oe(sd_dq_oe)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_mode(input logic [2:0] m);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_mode = m;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic issue(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                       input bit cfg_en, input logic [2:0] cfg_val);
    @(negedge clk);
    mem_req = 1'b1;
    mem_addr = a;
    mem_wdata = d;
    if (cfg_en) begin
      cfg_we = 1'b1;
      cfg_mode = cfg_val;
    end
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    c_cs = sd_cs_n; c_cmd = {sd_ras_n, sd_cas_n, sd_we_n};
    c_addr = sd_addr; c_ba = sd_ba; c_oe = sd_dq_oe; c_dq = sd_dq;
    c_ack0 = mem_ack;
    @(posedge clk);
    @(negedge clk);
    c_ack1 = mem_ack;
    c_cs1 = sd_cs_n;
    mem_req = 1'b0;
  endtask

  task automatic expect_cmd(input string tag, input logic [2:0] ecmd,
                            input logic [ROW_W-1:0] eaddr,
                            input logic [BANK_W-1:0] eba, input logic eoe);
    chk(c_cs == 1'b0, {tag, " cs low"}, 32'(c_cs), 0);
    chk(c_cmd == ecmd, {tag, " cmd"}, 32'(c_cmd), 32'(ecmd));
    chk(c_addr == eaddr, {tag, " addr"}, 32'(c_addr), 32'(eaddr));
    chk(c_ba == eba, {tag, " bank"}, 32'(c_ba), 32'(eba));
    chk(c_oe == eoe, {tag, " R12 oe"}, 32'(c_oe), 32'(eoe));
    // R9: ack only in the cycle after the command, command lasts one cycle
    chk(c_ack0 == 1'b0 && c_ack1 == 1'b1, {tag, " R9 ack timing"},
        32'({c_ack0, c_ack1}), 32'b01);
    chk(c_cs1 == 1'b1, {tag, " R9 cs one cycle"}, 32'(c_cs1), 1);
  endtask

  function automatic logic [ROW_W-1:0] row_of(input logic [ADDR_W-1:0] a);
    return a[ROW_W-1:0];
  endfunction
  function automatic logic [BANK_W-1:0] ba_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:ROW_W];
  endfunction

  task automatic t_reset;
    @(negedge clk);
    chk(sd_cs_n == 1'b1, "R1 cs", 32'(sd_cs_n), 1);
    chk({sd_ras_n, sd_cas_n, sd_we_n} == 3'b111, "R1 cmd",
        32'({sd_ras_n, sd_cas_n, sd_we_n}), 7);
    chk(mem_ack == 1'b0, "R1 ack", 32'(mem_ack), 0);
    chk(sd_dq_oe == 1'b0, "R1 oe", 32'(sd_dq_oe), 0);
  endtask

  task automatic t_normal;
    logic [ADDR_W-1:0] a;
    logic [ROW_W-1:0] ea;
    // mode field still at its reset value 0 (R1)
    a = 15'h5DEF;
    issue(a, 16'hA55A, 0, 0);
    ea = row_of(a); ea[10] = 1'b0;
    expect_cmd("R2 R1 write", 3'b100, ea, ba_of(a), 1'b1);
    chk(c_dq == 16'hA55A, "R2 data", 32'(c_dq), 32'hA55A);
    a = 15'h2123;
    issue(a, 16'h0F0F, 0, 0);
    expect_cmd("R2 write b", 3'b100, row_of(a), ba_of(a), 1'b1);
    chk(c_dq == 16'h0F0F, "R2 data b", 32'(c_dq), 32'h0F0F);
  endtask

  task automatic t_nop;
    set_mode(3'd1);
    issue(15'h7FFF, 16'h1234, 0, 0);
    expect_cmd("R3 nop", 3'b111, '0, '0, 1'b0);
  endtask

  task automatic t_prech;
    set_mode(3'd2);
    issue(15'h6ABC, 16'h0, 0, 0);
    expect_cmd("R4 precharge", 3'b010, 13'h0400, '0, 1'b0);
    issue(15'h0000, 16'h0, 0, 0);
    expect_cmd("R4 precharge zero addr", 3'b010, 13'h0400, '0, 1'b0);
  endtask

  task automatic t_lmr;
    set_mode(3'd3);
    issue(15'h0032, 16'h0, 0, 0);
    expect_cmd("R5 lmr", 3'b000, 13'h0032, 2'b00, 1'b0);
    issue(15'h1437, 16'h0, 0, 0);
    expect_cmd("R5 lmr a10", 3'b000, row_of(15'h1437), ba_of(15'h1437), 1'b0);
  endtask

  task automatic t_refresh;
    int n = 0;
    set_mode(3'd4);
    for (int i = 0; i < 4; i++) begin
      issue(15'(i * 777), 16'h0, 0, 0);
      expect_cmd("R6 R10 refresh", 3'b001, '0, '0, 1'b0);
      if (c_cmd == 3'b001 && c_cs == 1'b0) n++;
    end
    chk(n == 4, "R6 refresh count", 32'(n), 4);
  endtask

  task automatic t_xlmr;
    set_mode(3'd5);
    issue(15'h2020, 16'h0, 0, 0);
    expect_cmd("R7 xlmr", 3'b000, 13'h0020, 2'b01, 1'b0);
    issue(15'h4001, 16'h0, 0, 0);
    expect_cmd("R7 xlmr b", 3'b000, 13'h0001, 2'b10, 1'b0);
  endtask

  task automatic t_reserved;
    set_mode(3'd6);
    issue(15'h3333, 16'hFFFF, 0, 0);
    expect_cmd("R8 mode6", 3'b111, '0, '0, 1'b0);
    set_mode(3'd7);
    issue(15'h4444, 16'hFFFF, 0, 0);
    expect_cmd("R8 mode7", 3'b111, '0, '0, 1'b0);
  endtask

  task automatic t_collide;
    set_mode(3'd4);
    // mode written on the accepting edge: old mode (refresh) applies
    issue(15'h0100, 16'h0, 1, 3'd2);
    expect_cmd("R11 old mode", 3'b001, '0, '0, 1'b0);
    issue(15'h0100, 16'h0, 0, 0);
    expect_cmd("R11 new mode", 3'b010, 13'h0400, '0, 1'b0);
    // R10: still precharge after two writes
    issue(15'h0155, 16'h0, 0, 0);
    expect_cmd("R10 mode kept", 3'b010, 13'h0400, '0, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_normal();
    t_nop();
    t_prech();
    t_lmr();
    t_refresh();
    t_xlmr();
    t_reserved();
    t_collide();
    set_mode(3'd0);
    issue(15'h0011, 16'hBEEF, 0, 0);
    expect_cmd("R2 back to normal", 3'b100, 13'h0011, 2'b00, 1'b1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule